// File: doc/BRIEF.md
# Clock-Synchronous Serial Transceiver Master

This block moves one byte at a time over a three-wire synchronous link and supplies the link's shift clock. A system-clock prescaler divides the clock by 1, 8 or 32. A toggle stage then halves that again, giving a free-running internal shift clock with 50% duty. Software loads a byte with a write strobe. The block waits for the next falling edge of the internal clock. It then gates that clock onto the clock pin for exactly eight bit times. During those bit times it shifts the byte out on the data-out pin and collects eight bits from the data-in pin.

When the eighth bit has been sampled, the clock pin returns to its idle level and an interrupt-request flag is set. The received byte can then be read on the receive port. Control inputs select the following:

- clock polarity, which sets which pin edge launches data and which edge samples it
- bit order
- whether the data-out pin floats or keeps its last bit between transfers

The data-out pin is modelled as a value plus an active-high drive enable.

Top module: `sio_master`

## Requirements
- R1: The divider select gives a half-period of N system clocks, with N = 1 for code 0, N = 8 for code 1 and N = 32 for codes 2 and 3. Consecutive sampling edges on the clock pin are therefore 2N system clocks apart.
- R2: A write accepted while idle starts the transfer on a falling edge of the free-running internal clock. The first clock-pin edge appears 1 to 2N system clocks after the write edge, which is at most one shift-clock period.
- R3: Each transfer makes exactly 8 launch edges (the first one is the start) and 8 sampling edges on the clock pin. The pin then stays at its idle level until the next write.
- R4: With clk_pol = 0 the clock pin idles high, data changes on its falling edge and is sampled on its rising edge. With clk_pol = 1 the pin idles low and the two edges swap roles.
- R5: With msb_first = 0 the bits leave in the order bit 0 first, bit 7 last. With msb_first = 1 the order is reversed.
- R6: After out_en rises, sdo_oe stays 0 until the edge that launches the first bit of the next transfer. At that edge sdo_oe becomes 1 and sdo_o carries the first bit.
- R7: After the last sampling edge, sdo_oe falls to 0 when hold_out = 0. When hold_out = 1, sdo_oe stays 1 and sdo_o keeps the last transmitted bit.
- R8: irq_o becomes 1 at the edge of the last sampling edge and stays 1 until irq_clr is asserted.
- R9: After irq_o is set, rx_data holds the byte received on sdi. Bits sampled first land at bit 0 when msb_first = 0, and at bit 7 when msb_first = 1.
- R10: A write while a transfer is waiting or shifting is ignored. It starts no further transfer.
- R11: While enable or out_en is 0, sdo_oe is 0.
- R12: After reset, sdo_oe and irq_o are 0, rx_data is 0 and the clock pin is at its idle level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Block enable; 0 aborts and idles |
| out_en | input | 1 | Permits driving of the data-out pin |
| clk_pol | input | 1 | Clock polarity select |
| msb_first | input | 1 | Bit order select |
| hold_out | input | 1 | 1 keeps driving the last bit after a transfer |
| div_sel | input | 2 | Prescaler select |
| wr_en | input | 1 | Write strobe for the transmit byte |
| wr_data | input | 8 | Transmit byte |
| irq_clr | input | 1 | Clears the interrupt-request flag |
| rx_data | output | 8 | Received byte |
| irq_o | output | 1 | Interrupt-request flag |
| sclk_o | output | 1 | Shift clock pin |
| sdo_o | output | 1 | Serial data-out value |
| sdo_oe | output | 1 | Drive enable of the data-out pin |
| sdi | input | 1 | Serial data-in pin |

## Verification
A wrong bit counter shows up within one transfer as a ninth or missing seventh clock pulse, and the clock pin does not settle at its idle level. A wrong phase or prescaler state shows up on the very first pulse, either as a start latency outside 1 to 2N clocks or as a spacing between sampling edges other than 2N clocks. A bad drive-enable or hold register is visible in the idle gap before the first launch edge and in the gap after the last sampling edge. A misrouted shift path corrupts the captured or received byte at the end of the same transfer.

// File: rtl/sio_pkg.sv
package sio_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_SHIFT = 2'd2
  } xfer_state_t;

  typedef enum logic [1:0] {
    DIV_FAST  = 2'd0,
    DIV_MID   = 2'd1,
    DIV_SLOW  = 2'd2,
    DIV_SLOW2 = 2'd3
  } div_code_t;

endpackage

// File: rtl/sio_tick_gen.sv
module sio_tick_gen
  import sio_pkg::*;
#(
  parameter int MID_DIV  = 8,
  parameter int SLOW_DIV = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] div_sel,
  output logic       rise_tick,
  output logic       fall_tick,
  output logic       phase
);

  localparam int CNT_W = (SLOW_DIV > 1) ? $clog2(SLOW_DIV) : 1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] limit;
  logic             ph_q, ph_d;
  logic             tick;

  // Prescaler terminal count for the selected division.
  always_comb begin
    case (div_code_t'(div_sel))
      DIV_FAST: limit = '0;
      DIV_MID:  limit = CNT_W'(MID_DIV - 1);
      default:  limit = CNT_W'(SLOW_DIV - 1);
    endcase
  end

  assign tick = (cnt_q >= limit);

  always_comb begin
    cnt_d = tick ? '0 : cnt_q + 1'b1;
    ph_d  = tick ? ~ph_q : ph_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ph_q  <= 1'b1;
    end else begin
      cnt_q <= cnt_d;
      ph_q  <= ph_d;
    end
  end

  assign rise_tick = tick & ~ph_q;
  assign fall_tick = tick & ph_q;
  assign phase     = ph_q;

endmodule

// File: rtl/sio_shift.sv
module sio_shift #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              msb_first,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              shift_en,
  input  logic              sample_en,
  input  logic              sdi,
  output logic              tx_bit,
  output logic [DATA_W-1:0] rx_word
);

  logic [DATA_W-1:0] tx_q, tx_d, tx_step;
  logic [DATA_W-1:0] rx_q, rx_d, rx_step;

  // Per-bit neighbour selection for both shift directions.
  genvar gi;
  generate
    for (gi = 0; gi < DATA_W; gi++) begin : g_lane
      if (gi == 0) begin : g_low
        assign tx_step[gi] = msb_first ? 1'b0 : tx_q[gi+1];
        assign rx_step[gi] = msb_first ? sdi : rx_q[gi+1];
      end else if (gi == DATA_W - 1) begin : g_high
        assign tx_step[gi] = msb_first ? tx_q[gi-1] : 1'b0;
        assign rx_step[gi] = msb_first ? rx_q[gi-1] : sdi;
      end else begin : g_mid
        assign tx_step[gi] = msb_first ? tx_q[gi-1] : tx_q[gi+1];
        assign rx_step[gi] = msb_first ? rx_q[gi-1] : rx_q[gi+1];
      end
    end
  endgenerate

  always_comb begin
    tx_d = tx_q;
    if (load) begin
      tx_d = load_data;
    end else if (shift_en) begin
      tx_d = tx_step;
    end
    rx_d = sample_en ? rx_step : rx_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q <= '0;
      rx_q <= '0;
    end else begin
      tx_q <= tx_d;
      rx_q <= rx_d;
    end
  end

  assign tx_bit  = msb_first ? tx_q[DATA_W-1] : tx_q[0];
  assign rx_word = rx_q;

endmodule

// File: rtl/sio_seq.sv
module sio_seq
  import sio_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              out_en,
  input  logic              hold_out,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              irq_clr,
  input  logic              rise_tick,
  input  logic              fall_tick,
  output logic              load,
  output logic [DATA_W-1:0] tx_hold,
  output logic              shift_en,
  output logic              sample_en,
  output logic              in_shift,
  output logic              busy,
  output logic [$clog2(DATA_W)-1:0] bit_idx,
  output logic              sdo_oe,
  output logic              irq_o
);

  localparam int IDX_W = $clog2(DATA_W);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_W - 1);

  xfer_state_t       st_q, st_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [DATA_W-1:0] hold_q, hold_d;
  logic              drive_q, drive_d;
  logic              irq_q, irq_d;
  logic              done;

  always_comb begin
    st_d      = st_q;
    idx_d     = idx_q;
    hold_d    = hold_q;
    done      = 1'b0;
    load      = 1'b0;
    shift_en  = 1'b0;
    sample_en = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (enable && wr_en) begin
          st_d   = ST_WAIT;
          hold_d = wr_data;
        end
      end
      ST_WAIT: begin
        if (!enable) begin
          st_d = ST_IDLE;
        end else if (fall_tick) begin
          st_d  = ST_SHIFT;
          idx_d = '0;
          load  = 1'b1;
        end
      end
      ST_SHIFT: begin
        if (!enable) begin
          st_d = ST_IDLE;
        end else begin
          shift_en = fall_tick;
          if (rise_tick) begin
            sample_en = 1'b1;
            if (idx_q == LAST_IDX) begin
              st_d = ST_IDLE;
              done = 1'b1;
            end else begin
              idx_d = idx_q + 1'b1;
            end
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // Drive enable and interrupt flag next state.
  always_comb begin
    drive_d = drive_q;
    if (!(enable && out_en)) begin
      drive_d = 1'b0;
    end else if (load) begin
      drive_d = 1'b1;
    end else if (done && !hold_out) begin
      drive_d = 1'b0;
    end
    irq_d = irq_q;
    if (done) begin
      irq_d = 1'b1;
    end else if (irq_clr) begin
      irq_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      idx_q   <= '0;
      hold_q  <= '0;
      drive_q <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      st_q    <= st_d;
      idx_q   <= idx_d;
      hold_q  <= hold_d;
      drive_q <= drive_d;
      irq_q   <= irq_d;
    end
  end

  assign in_shift = (st_q == ST_SHIFT);
  assign busy     = (st_q != ST_IDLE);
  assign bit_idx  = idx_q;
  assign tx_hold  = hold_q;
  assign sdo_oe   = drive_q & enable & out_en;
  assign irq_o    = irq_q;

endmodule

// File: rtl/sio_master.sv
module sio_master
  import sio_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int MID_DIV  = 8,
  parameter int SLOW_DIV = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              out_en,
  input  logic              clk_pol,
  input  logic              msb_first,
  input  logic              hold_out,
  input  logic [1:0]        div_sel,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              irq_clr,
  output logic [DATA_W-1:0] rx_data,
  output logic              irq_o,
  output logic              sclk_o,
  output logic              sdo_o,
  output logic              sdo_oe,
  input  logic              sdi
);

  localparam int IDX_W = $clog2(DATA_W);

  logic              rise_tick, fall_tick, phase;
  logic              load, shift_en, sample_en;
  logic              in_shift, busy;
  logic [IDX_W-1:0]  bit_idx;
  logic [DATA_W-1:0] tx_hold;

  sio_tick_gen #(
    .MID_DIV  (MID_DIV),
    .SLOW_DIV (SLOW_DIV)
  ) u_tick (
    .clk       (clk),
    .rst_n     (rst_n),
    .div_sel   (div_sel),
    .rise_tick (rise_tick),
    .fall_tick (fall_tick),
    .phase     (phase)
  );

  sio_seq #(
    .DATA_W (DATA_W)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .out_en    (out_en),
    .hold_out  (hold_out),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .irq_clr   (irq_clr),
    .rise_tick (rise_tick),
    .fall_tick (fall_tick),
    .load      (load),
    .tx_hold   (tx_hold),
    .shift_en  (shift_en),
    .sample_en (sample_en),
    .in_shift  (in_shift),
    .busy      (busy),
    .bit_idx   (bit_idx),
    .sdo_oe    (sdo_oe),
    .irq_o     (irq_o)
  );

  sio_shift #(
    .DATA_W (DATA_W)
  ) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .msb_first (msb_first),
    .load      (load),
    .load_data (tx_hold),
    .shift_en  (shift_en),
    .sample_en (sample_en),
    .sdi       (sdi),
    .tx_bit    (sdo_o),
    .rx_word   (rx_data)
  );

  // Gated shift clock: follows the internal phase only while shifting.
  assign sclk_o = in_shift ? (phase ^ clk_pol) : ~clk_pol;

endmodule

// File: rtl/sio_master_chk.sv
module sio_master_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              enable,
  input logic              out_en,
  input logic              clk_pol,
  input logic              wr_en,
  input logic              sclk_o,
  input logic              sdo_o,
  input logic              sdo_oe,
  input logic              irq_o,
  input logic              in_shift,
  input logic              busy,
  input logic              phase,
  input logic [DATA_W-1:0] tx_hold
);

  assert_oe_gated_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(enable && out_en) |-> !sdo_oe);

  assert_idle_level_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !in_shift |-> (sclk_o == !clk_pol));

  assert_irq_on_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> ($past(in_shift) && !in_shift));

  assert_start_phase_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_shift) |-> !phase);

  assert_sample_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(in_shift) && $stable(clk_pol) && (sclk_o != $past(sclk_o)) && (sclk_o == !clk_pol))
      |-> $stable(sdo_o));

  assert_busy_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_en) |=> $stable(tx_hold));

endmodule

bind sio_master sio_master_chk #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .enable   (enable),
  .out_en   (out_en),
  .clk_pol  (clk_pol),
  .wr_en    (wr_en),
  .sclk_o   (sclk_o),
  .sdo_o    (sdo_o),
  .sdo_oe   (sdo_oe),
  .irq_o    (irq_o),
  .in_shift (in_shift),
  .busy     (busy),
  .phase    (phase),
  .tx_hold  (tx_hold)
);

// File: tb/tb_sio_master.sv
`timescale 1ns/1ps
module tb_sio_master;

  logic       clk;
  logic       rst_n;
  logic       enable, out_en, clk_pol, msb_first, hold_out;
  logic [1:0] div_sel;
  logic       wr_en;
  logic [7:0] wr_data;
  logic       irq_clr;
  logic [7:0] rx_data;
  logic       irq_o, sclk_o, sdo_o, sdo_oe, sdi;

  int n_cmp;
  int n_bad;
  int n;
  logic exp_oe;

  sio_master dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .out_en    (out_en),
    .clk_pol   (clk_pol),
    .msb_first (msb_first),
    .hold_out  (hold_out),
    .div_sel   (div_sel),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .irq_clr   (irq_clr),
    .rx_data   (rx_data),
    .irq_o     (irq_o),
    .sclk_o    (sclk_o),
    .sdo_o     (sdo_o),
    .sdo_oe    (sdo_oe),
    .sdi       (sdi)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h (div=%0d pol=%0b msb=%0b hold=%0b)",
               tag, act, exp, div_sel, clk_pol, msb_first, hold_out);
    end
  endtask

  function automatic logic [7:0] bitrev(input logic [7:0] v);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = v[7-i];
    return r;
  endfunction

  task automatic run_xfer(input logic [7:0] tx, input logic [7:0] sx, input bit poke);
    logic [7:0] cap;
    logic [7:0] exp_cap;
    logic       idle_lvl, prev_pin, prev_sdo, prev_oe, last_bit;
    int         lat, ns, nc, cyc, last_s;
    bit         oe_wait_ok, oe_ok, per_ok, quiet_ok;
    idle_lvl   = ~clk_pol;
    exp_cap    = msb_first ? bitrev(tx) : tx;
    sdi        = msb_first ? sx[7] : sx[0];
    oe_wait_ok = 1'b1;
    @(negedge clk);
    wr_en   = 1'b1;
    wr_data = tx;
    @(negedge clk);
    wr_en   = 1'b0;
    wr_data = ~tx;
    lat     = 0;
    while (sclk_o == idle_lvl && lat < 4 * n) begin
      if (sdo_oe !== exp_oe) oe_wait_ok = 1'b0;
      @(negedge clk);
      lat++;
    end
    check(lat >= 1 && lat <= 2 * n, "R2 start latency", lat, 2 * n);
    check(oe_wait_ok, "R6 data-out drive before first bit", 0, 1);
    check(sdo_oe === 1'b1 && sdo_o === exp_cap[0], "R6 first bit driven at start",
          {sdo_oe, sdo_o}, {1'b1, exp_cap[0]});
    prev_pin = sclk_o;
    prev_sdo = sdo_o;
    prev_oe  = sdo_oe;
    ns = 0; nc = 1; cyc = 0; last_s = -1;
    oe_ok = 1'b1; per_ok = 1'b1; cap = '0;
    while (ns < 8 && cyc < 40 * n) begin
      if (poke && cyc == 3 * n) begin
        wr_en   = 1'b1;
        wr_data = ~tx;
      end else begin
        wr_en = 1'b0;
      end
      @(negedge clk);
      cyc++;
      if (sclk_o != prev_pin) begin
        if (sclk_o == idle_lvl) begin
          cap[ns] = prev_sdo;
          if (!prev_oe) oe_ok = 1'b0;
          if (last_s >= 0 && (cyc - last_s) != 2 * n) per_ok = 1'b0;
          last_s = cyc;
          ns++;
        end else begin
          if (nc < 8) sdi = msb_first ? sx[7-nc] : sx[nc];
          nc++;
        end
      end
      prev_pin = sclk_o;
      prev_sdo = sdo_o;
      prev_oe  = sdo_oe;
    end
    wr_en = 1'b0;
    check(ns == 8, "R3 sampling edge count", ns, 8);
    check(nc == 8, "R3 launch edge count", nc, 8);
    check(per_ok, "R1 sampling edge spacing 2N", 0, 2 * n);
    check(oe_ok, "R6 drive during bits", 0, 1);
    check(cap == exp_cap, "R5 bit order on data-out", cap, exp_cap);
    check(irq_o === 1'b1, "R8 flag on completion", irq_o, 1);
    check(rx_data == sx, "R9 received byte", rx_data, sx);
    check(sdo_oe === hold_out, "R7 drive after transfer", sdo_oe, hold_out);
    check(sclk_o === idle_lvl, "R4 clock idle level", sclk_o, idle_lvl);
    last_bit = exp_cap[7];
    quiet_ok = 1'b1;
    for (int k = 0; k < 4 * n + 4; k++) begin
      @(negedge clk);
      if (sclk_o !== idle_lvl || sdo_oe !== hold_out) quiet_ok = 1'b0;
      if (hold_out && sdo_o !== last_bit) quiet_ok = 1'b0;
    end
    if (poke) check(quiet_ok, "R10 busy write ignored", 0, 1);
    else      check(quiet_ok, "R7 R3 quiet after transfer", 0, 1);
    @(negedge clk);
    irq_clr = 1'b1;
    @(negedge clk);
    irq_clr = 1'b0;
    check(irq_o === 1'b0, "R8 flag cleared", irq_o, 0);
    exp_oe = hold_out;
  endtask

  initial begin
    n_cmp = 0; n_bad = 0;
    rst_n = 1'b0;
    enable = 1'b0; out_en = 1'b0; clk_pol = 1'b0; msb_first = 1'b0; hold_out = 1'b0;
    div_sel = 2'd0; wr_en = 1'b0; wr_data = '0; irq_clr = 1'b0; sdi = 1'b0;
    exp_oe = 1'b0; n = 1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(sclk_o === 1'b1 && sdo_oe === 1'b0 && irq_o === 1'b0 && rx_data == 8'h00,
          "R12 reset state", {sclk_o, sdo_oe, irq_o}, 3'b100);
    enable = 1'b1;
    for (int d = 0; d < 4; d++) begin
      for (int cfg = 0; cfg < 8; cfg++) begin
        if (d == 3 && cfg > 1) continue;
        @(negedge clk);
        out_en = 1'b0;
        @(negedge clk);
        check(sdo_oe === 1'b0, "R11 drive off while output disabled", sdo_oe, 0);
        div_sel   = 2'(d);
        n         = (d == 0) ? 1 : (d == 1) ? 8 : 32;
        clk_pol   = cfg[0];
        msb_first = cfg[1];
        hold_out  = cfg[2];
        repeat (2) @(negedge clk);
        out_en = 1'b1;
        exp_oe = 1'b0;
        @(negedge clk);
        check(sdo_oe === 1'b0, "R6 high impedance after output enable", sdo_oe, 0);
        run_xfer(8'(8'hA5 ^ (d * 37 + cfg * 11)), 8'(8'h3C + d * 53 + cfg * 7), 1'b0);
        run_xfer(8'(8'h1E + d * 29 + cfg * 13), 8'(8'hD2 ^ (d * 17 + cfg * 5)), 1'b1);
      end
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule